// File: doc/BRIEF.md
# Multi-Sensor Frame Combiner

This block sits between three sensor receivers and a single video output. One sensor stream goes straight to the output. Two more streams are recorded elsewhere and played back on request. A routing register chooses which sensor feeds each of the three paths, and a mode register chooses what the output carries.

In bypass mode the direct sensor is simply forwarded. In sequencing mode a live frame is followed by the two played-back frames. The block asks for each played-back frame with a one-cycle start pulse and waits for its done pulse before it moves on. The frames can share one frame-valid window, or each can be sent as its own frame with a programmable idle gap before it. When the frames share one window, the line-valid of either played-back frame can be moved one clock later. An output disable, a sequencer reset and a test-pattern data source round out the mode register. All video outputs are registered, so they follow the inputs by one clock.

Top module: `frame_merger`

## Requirements
- R1: While `rst_n` is low, `out_fv`, `out_lv`, `out_d` and `buf_start` are all zero.
- R2: Routing bits [1:0] select the direct sensor: code 1, 2 or 3 picks sensor lane 0, 1 or 2 (the fv/lv bit of that index and data slice `sens_d[DW*i +: DW]`). Code 0 selects nothing, and all outputs are then low. Outputs appear one clock after their inputs.
- R3: With mode bit 2 clear (bypass), the direct sensor's fv, lv and data are forwarded and `buf_start` stays zero.
- R4: With mode bit 2 set, the following happens after the direct sensor's frame-valid rises and then falls. `buf_start[0]` pulses for exactly one cycle. After `buf_done[0]`, `buf_start[1]` pulses for one cycle. After `buf_done[1]`, the block returns to idle. While a played-back frame is active, the output carries `buf_lv[k]` and `buf_d[DW*k +: DW]`.
- R5: A routing code of 0 in bits [3:2] skips the first played-back frame, and a code of 0 in bits [5:4] skips the second. No start pulse is issued for a skipped frame.
- R6: With mode bit 4 clear, `out_fv` stays high without a break from the start of the live frame until the last played-back frame is done.
- R7: With mode bit 4 set, `out_fv` is low between frames. A start pulse is issued `cfg_gap` cycles later than it would be with a gap of 0.
- R8: With mode bit 4 clear, `cfg_lv_dly` bit k delays the line-valid of played-back frame k by one clock, and its data is not delayed. With mode bit 4 set, the delay bits have no effect.
- R9: Mode bit 1 forces all three video outputs low from the next cycle. Start pulses continue to be issued.
- R10: Mode bit 0 returns the sequencer to idle, including in the middle of a sequence. While it is set, no start pulse is issued and the outputs are low.
- R11: Mode bit 5 replaces the output data with the count of line-valid cycles already seen in the current line (0, 1, 2, ...). Frame and line timing are unchanged.
- R12: `rec_src0` equals routing bits [3:2]. `rec_src1` is 0 when routing bits [5:4] are 0. Otherwise it is 3 when mode bit 3 is set and 2 when mode bit 3 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_route | input | 6 | Path routing codes |
| cfg_mode | input | 6 | Mode bits |
| cfg_gap | input | GAPW | Idle cycles before each played-back frame in separate mode |
| cfg_lv_dly | input | 2 | Per played-back frame one-clock line-valid delay |
| sens_fv | input | 3 | Sensor frame-valid |
| sens_lv | input | 3 | Sensor line-valid |
| sens_d | input | 3*DW | Sensor pixel data, lane i at [DW*i +: DW] |
| buf_lv | input | 2 | Played-back line-valid |
| buf_d | input | 2*DW | Played-back pixel data |
| buf_done | input | 2 | Played-back frame finished |
| buf_start | output | 2 | One-cycle request to start playback |
| rec_src0 | output | 2 | Sensor code recorded by first buffer |
| rec_src1 | output | 2 | Sensor code recorded by second buffer |
| out_fv | output | 1 | Output frame-valid |
| out_lv | output | 1 | Output line-valid |
| out_d | output | DW | Output pixel data |

## Verification
The bench builds the block with DW=8 and GAPW=4. With these values the three sensor lanes pack into one readable 24-bit word, and a gap of 3 sits well inside the counter range, so the distance from the end of a frame to its start pulse can be checked cycle by cycle. The short frames used are one to three cycles long. They reach every sequencer state, including a skipped frame, a reset in the middle of a sequence, and the line-valid delay bits set in both output modes.

// File: rtl/frame_merger.sv
module frame_merger #(
  parameter int DW   = 8,
  parameter int GAPW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [5:0]      cfg_route,
  input  logic [5:0]      cfg_mode,
  input  logic [GAPW-1:0] cfg_gap,
  input  logic [1:0]      cfg_lv_dly,
  input  logic [2:0]      sens_fv,
  input  logic [2:0]      sens_lv,
  input  logic [3*DW-1:0] sens_d,
  input  logic [1:0]      buf_lv,
  input  logic [2*DW-1:0] buf_d,
  input  logic [1:0]      buf_done,
  output logic [1:0]      buf_start,
  output logic [1:0]      rec_src0,
  output logic [1:0]      rec_src1,
  output logic            out_fv,
  output logic            out_lv,
  output logic [DW-1:0]   out_d
);

  typedef enum logic [2:0] {S_IDLE, S_LIVE, S_GAP, S_START, S_BUF} st_t;

  st_t            st;
  logic           idx;
  logic [GAPW-1:0] gcnt;
  logic           dfv_q;
  logic [1:0]     blv_q;
  logic [DW-1:0]  tp_cnt;

  logic           dfv, dlv;
  logic [DW-1:0]  dd;
  logic           src_fv, src_lv;
  logic [DW-1:0]  src_d;

  wire en0    = cfg_route[3:2] != 2'd0;
  wire en1    = cfg_route[5:4] != 2'd0;
  wire seq_on = cfg_mode[2];
  wire sep    = cfg_mode[4];
  wire halt   = cfg_mode[0] | ~cfg_mode[2];
  wire quiet  = cfg_mode[0] | cfg_mode[1];
  wire to_gap = sep && (cfg_gap != '0);

  assign rec_src0  = cfg_route[3:2];
  assign rec_src1  = en1 ? (cfg_mode[3] ? 2'd3 : 2'd2) : 2'd0;
  assign buf_start = (st == S_START) ? (idx ? 2'b10 : 2'b01) : 2'b00;

  always_comb begin
    dfv = 1'b0;
    dlv = 1'b0;
    dd  = '0;
    case (cfg_route[1:0])
      2'd1: begin dfv = sens_fv[0]; dlv = sens_lv[0]; dd = sens_d[0 +: DW]; end
      2'd2: begin dfv = sens_fv[1]; dlv = sens_lv[1]; dd = sens_d[DW +: DW]; end
      2'd3: begin dfv = sens_fv[2]; dlv = sens_lv[2]; dd = sens_d[2*DW +: DW]; end
      default: ;
    endcase
  end

  always_comb begin
    src_fv = dfv;
    src_lv = dlv;
    src_d  = dd;
    if (seq_on) begin
      case (st)
        S_LIVE:  src_fv = sep ? dfv : 1'b1;
        S_GAP:   begin src_fv = 1'b0; src_lv = 1'b0; src_d = '0; end
        S_START: begin src_fv = ~sep; src_lv = 1'b0; src_d = '0; end
        S_BUF: begin
          src_fv = 1'b1;
          src_lv = (!sep && cfg_lv_dly[idx]) ? blv_q[idx] : buf_lv[idx];
          src_d  = idx ? buf_d[DW +: DW] : buf_d[0 +: DW];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= 1'b0;
      gcnt   <= '0;
      dfv_q  <= 1'b0;
      blv_q  <= 2'b00;
      tp_cnt <= '0;
      out_fv <= 1'b0;
      out_lv <= 1'b0;
      out_d  <= '0;
    end else begin
      dfv_q <= dfv;
      blv_q <= buf_lv;
      if (halt) begin
        st  <= S_IDLE;
        idx <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (dfv && !dfv_q) st <= S_LIVE;
          S_LIVE: if (!dfv) begin
            if (en0 || en1) begin
              idx  <= !en0;
              gcnt <= {{(GAPW-1){1'b0}}, 1'b1};
              st   <= to_gap ? S_GAP : S_START;
            end else begin
              st <= S_IDLE;
            end
          end
          S_GAP: begin
            if (gcnt >= cfg_gap) st <= S_START;
            else gcnt <= gcnt + 1'b1;
          end
          S_START: st <= S_BUF;
          S_BUF: if (buf_done[idx]) begin
            if (!idx && en1) begin
              idx  <= 1'b1;
              gcnt <= {{(GAPW-1){1'b0}}, 1'b1};
              st   <= to_gap ? S_GAP : S_START;
            end else begin
              st <= S_IDLE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
      tp_cnt <= src_lv ? tp_cnt + 1'b1 : '0;
      out_fv <= quiet ? 1'b0 : src_fv;
      out_lv <= quiet ? 1'b0 : src_lv;
      out_d  <= quiet ? '0 : (cfg_mode[5] ? tp_cnt : src_d);
    end
  end

  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_start != 2'b00) |=> (buf_start == 2'b00));

  p_bypass_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode[2] |=> (buf_start == 2'b00));

  p_reset_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode[0] |=> (buf_start == 2'b00));

  p_disable_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode[1] |=> (!out_fv && !out_lv && out_d == '0));

  p_merged_fv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && cfg_mode[2] && !cfg_mode[4] && cfg_mode[1:0] == 2'b00) |=> out_fv);

endmodule

// File: tb/sim_frame_merger.sv
module sim_frame_merger;
  localparam int DW = 8;
  localparam int GAPW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] cfg_route = '0, cfg_mode = '0;
  logic [GAPW-1:0] cfg_gap = '0;
  logic [1:0] cfg_lv_dly = '0;
  logic [2:0] sens_fv = '0, sens_lv = '0;
  logic [3*DW-1:0] sens_d = '0;
  logic [1:0] buf_lv = '0, buf_done = '0;
  logic [2*DW-1:0] buf_d = '0;
  logic [1:0] buf_start, rec_src0, rec_src1;
  logic out_fv, out_lv;
  logic [DW-1:0] out_d;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  frame_merger #(.DW(DW), .GAPW(GAPW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_route(cfg_route), .cfg_mode(cfg_mode),
    .cfg_gap(cfg_gap), .cfg_lv_dly(cfg_lv_dly), .sens_fv(sens_fv), .sens_lv(sens_lv),
    .sens_d(sens_d), .buf_lv(buf_lv), .buf_d(buf_d), .buf_done(buf_done),
    .buf_start(buf_start), .rec_src0(rec_src0), .rec_src1(rec_src1),
    .out_fv(out_fv), .out_lv(out_lv), .out_d(out_d));

  // route[41:40] fv[39:37] lv[36:34] d[33:10] exp_fv[9] exp_lv[8] exp_d[7:0]
  localparam logic [41:0] VEC [6] = '{
    {2'd1, 3'b001, 3'b001, 24'h332211, 1'b1, 1'b1, 8'h11},
    {2'd2, 3'b010, 3'b000, 24'h332211, 1'b1, 1'b0, 8'h22},
    {2'd3, 3'b100, 3'b100, 24'h332211, 1'b1, 1'b1, 8'h33},
    {2'd0, 3'b111, 3'b111, 24'h332211, 1'b0, 1'b0, 8'h00},
    {2'd2, 3'b101, 3'b101, 24'h332211, 1'b0, 1'b0, 8'h22},
    {2'd3, 3'b011, 3'b011, 24'h332211, 1'b0, 1'b0, 8'h33}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle_all();
    cfg_mode = 6'h00; sens_fv = '0; sens_lv = '0; buf_lv = '0; buf_done = '0;
    cyc(); cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    sens_d = 24'h332211;
    cyc(); cyc();
    chk("R1 fv", out_fv, 0); chk("R1 lv", out_lv, 0);
    chk("R1 d", out_d, 0); chk("R1 start", buf_start, 0);
    rst_n = 1'b1;
    cyc();

    // R2 / R3 vector walk in bypass mode
    for (int i = 0; i < 6; i++) begin
      cfg_route = {4'b0, VEC[i][41:40]};
      sens_fv = VEC[i][39:37]; sens_lv = VEC[i][36:34]; sens_d = VEC[i][33:10];
      cyc();
      chk("R2 fv", out_fv, VEC[i][9]);
      chk("R2 lv", out_lv, VEC[i][8]);
      chk("R3 d", out_d, VEC[i][7:0]);
      chk("R3 start", buf_start, 0);
    end
    idle_all();

    // R12 record sources
    cfg_route = 6'h39; cfg_mode = 6'h08; #1;
    chk("R12 src0", rec_src0, 2); chk("R12 src1 m3", rec_src1, 3);
    cfg_mode = 6'h00; #1; chk("R12 src1 m0", rec_src1, 2);
    cfg_route = 6'h09; #1; chk("R12 src1 off", rec_src1, 0);

    // R4 / R6 merged sequence
    cfg_route = 6'h39; cfg_mode = 6'h04; cfg_gap = 0; cfg_lv_dly = 0;
    cyc();
    sens_fv = 3'b001; sens_lv = 3'b001; sens_d = 24'h000011; cyc();
    chk("R4 live fv", out_fv, 1); chk("R4 live lv", out_lv, 1); chk("R4 live d", out_d, 8'h11);
    sens_fv = 0; sens_lv = 0; cyc();
    chk("R6 fv", out_fv, 1); chk("R4 start0", buf_start, 2'b01);
    cyc();
    chk("R4 pulse", buf_start, 0); chk("R6 fv", out_fv, 1);
    buf_lv = 2'b01; buf_d = 16'h0022; cyc();
    chk("R4 b0 lv", out_lv, 1); chk("R4 b0 d", out_d, 8'h22);
    buf_lv = 0; buf_done = 2'b01; cyc();
    chk("R6 fv", out_fv, 1); chk("R4 start1", buf_start, 2'b10);
    buf_done = 0; cyc();
    chk("R4 pulse1", buf_start, 0);
    buf_lv = 2'b10; buf_d = 16'h3300; cyc();
    chk("R4 b1 lv", out_lv, 1); chk("R4 b1 d", out_d, 8'h33);
    buf_lv = 0; buf_done = 2'b10; cyc();
    chk("R6 fv end", out_fv, 1);
    buf_done = 0; cyc();
    chk("R4 idle fv", out_fv, 0); chk("R4 idle start", buf_start, 0);
    idle_all();

    // R8 delay, R5 second skipped
    cfg_route = 6'h09; cfg_mode = 6'h04; cfg_lv_dly = 2'b01; cyc();
    sens_fv = 3'b001; cyc();
    sens_fv = 0; cyc();
    chk("R5 start0", buf_start, 2'b01);
    cyc();
    buf_lv = 2'b01; buf_d = 16'h0044; cyc();
    chk("R8 delayed lv", out_lv, 0); chk("R8 data", out_d, 8'h44);
    buf_lv = 0; buf_done = 2'b01; cyc();
    chk("R8 lv late", out_lv, 1); chk("R5 no start1", buf_start, 0);
    buf_done = 0; cyc();
    chk("R5 idle fv", out_fv, 0); chk("R5 idle start", buf_start, 0);
    idle_all();

    // R5 first skipped
    cfg_route = 6'h31; cfg_mode = 6'h04; cfg_lv_dly = 0; cyc();
    sens_fv = 3'b001; cyc();
    sens_fv = 0; cyc();
    chk("R5 skip first", buf_start, 2'b10);
    idle_all();

    // R7 separate frames with gap, R8 delay ignored
    cfg_route = 6'h39; cfg_mode = 6'h14; cfg_gap = 3; cfg_lv_dly = 2'b11; cyc();
    sens_fv = 3'b001; cyc();
    chk("R7 live fv", out_fv, 1);
    sens_fv = 0; cyc();
    chk("R7 fv low", out_fv, 0); chk("R7 no start", buf_start, 0);
    cyc(); chk("R7 gap", buf_start, 0);
    cyc(); chk("R7 gap", buf_start, 0);
    cyc(); chk("R7 start0", buf_start, 2'b01); chk("R7 fv low", out_fv, 0);
    cyc(); chk("R7 start fv", out_fv, 0);
    buf_lv = 2'b01; buf_d = 16'h0055; cyc();
    chk("R7 frame fv", out_fv, 1); chk("R8 no delay", out_lv, 1); chk("R7 d", out_d, 8'h55);
    buf_lv = 0; buf_done = 2'b01; cyc();
    buf_done = 0; cyc();
    chk("R7 between fv", out_fv, 0);
    cyc(); chk("R7 gap2", buf_start, 0);
    cyc(); chk("R7 start1", buf_start, 2'b10);
    idle_all();

    // R9 disable
    cfg_route = 6'h39; cfg_mode = 6'h06; cfg_gap = 0; cfg_lv_dly = 0; cyc();
    sens_fv = 3'b001; sens_lv = 3'b001; sens_d = 24'h0000ff; cyc();
    chk("R9 fv", out_fv, 0); chk("R9 lv", out_lv, 0); chk("R9 d", out_d, 0);
    sens_fv = 0; sens_lv = 0; cyc();
    chk("R9 start", buf_start, 2'b01);
    idle_all();

    // R10 global reset
    cfg_route = 6'h39; cfg_mode = 6'h05; cyc();
    sens_fv = 3'b001; cyc();
    chk("R10 fv", out_fv, 0);
    sens_fv = 0; cyc();
    chk("R10 no start", buf_start, 0);
    cyc(); chk("R10 no start", buf_start, 0);
    cfg_mode = 6'h04; cyc();
    sens_fv = 3'b001; cyc();
    sens_fv = 0; cyc();
    chk("R10 seq start", buf_start, 2'b01);
    cfg_mode = 6'h05; cyc();
    chk("R10 aborted", buf_start, 0);
    cfg_mode = 6'h04; buf_done = 2'b01; cyc();
    chk("R10 stays idle", buf_start, 0);
    buf_done = 0; cyc();
    chk("R10 stays idle", buf_start, 0);
    idle_all();

    // R11 test pattern
    cfg_route = 6'h01; cfg_mode = 6'h20; cyc();
    sens_fv = 3'b001; sens_lv = 3'b001; sens_d = 24'h0000aa; cyc();
    chk("R11 px0", out_d, 0); chk("R11 lv", out_lv, 1);
    cyc(); chk("R11 px1", out_d, 1);
    cyc(); chk("R11 px2", out_d, 2); chk("R11 fv", out_fv, 1);
    idle_all();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule